// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Fetch Sequencer

This block owns the program counter and the fetch/decode pipeline register of a five-stage in-order core. Each cycle it presents the current PC as the instruction memory address and, on the next edge, captures the returned word together with the address of the next sequential instruction. While that word sits in the decode register, the block checks whether it is a branch-if-equal. It compares the two register operand values that the register file returns for it, and forms the branch destination from the sign-extended, word-scaled immediate added to the sequential address.

Because the branch is settled in decode, only one instruction behind it has been fetched when the outcome is known. A mode input picks what happens to that instruction. In squash mode a taken branch turns it into an all-zero no-op before it reaches decode. In delay-slot mode it always proceeds. A branch that is not taken costs nothing. A stall input freezes the PC and the decode register, and it blocks any redirect for that cycle.

Top module: `brf_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes `RESET_PC` (0x00000000 by default), and the decode register's instruction word and sequential address both become 0x00000000. `br_taken` is low while `rst` is high.
- R2: With no stall and no taken branch, `imem_addr` advances by 4 on every rising edge.
- R3: With no stall and no squash, on each rising edge `ifid_instr` takes the value of `imem_rdata` and `ifid_pc4` takes `imem_addr + 4`, both sampled before that edge.
- R4: `br_taken` is high exactly when `ifid_instr[31:26]` equals 6'b000100, `rs_val == rs_val`'s partner `rt_val` matches it (`rs_val == rt_val`), and `stall` is low. An unequal compare leaves fetch sequential with no lost cycle.
- R5: After a rising edge at which `br_taken` was high, `imem_addr` equals `ifid_pc4 + (sign-extended ifid_instr[15:0] << 2)`, with both operands taken before that edge.
- R6: With `delay_mode` low, a taken branch replaces the instruction being fetched behind it. After that edge, `ifid_instr` and `ifid_pc4` are both 0x00000000.
- R7: With `delay_mode` high, the instruction fetched behind a taken branch enters the decode register unchanged, with its own sequential address.
- R8: While `stall` is high, `imem_addr`, `ifid_instr` and `ifid_pc4` keep their values across the edge, and `br_taken` is low.
- R9: A decode-register opcode other than 6'b000100 never redirects fetch, even when the operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| delay_mode | input | 1 | 1 = the instruction after a branch executes; 0 = it is squashed when the branch is taken |
| imem_rdata | input | 32 | Instruction word read at `imem_addr` |
| rs_val | input | 32 | First register operand of the instruction in decode |
| rt_val | input | 32 | Second register operand of the instruction in decode |
| stall | input | 1 | Freeze PC and decode register; block redirect |
| imem_addr | output | 32 | Current PC, used as the instruction fetch address |
| ifid_instr | output | 32 | Instruction word held in the decode register |
| ifid_pc4 | output | 32 | Sequential address belonging to the decode instruction |
| br_taken | output | 1 | Branch in decode is taken this cycle |

## Verification
A PC that takes the wrong value shows on `imem_addr` right after the edge that produced it, and it reaches `ifid_instr` and `ifid_pc4` one edge later. A squash that goes wrong, either missed or applied when it should not be, shows as the wrong decode word at the first negative edge after the branch resolves. A wrong target shows on the next fetch address. The sweep covers both modes, taken and not-taken outcomes, backward and forward offsets, stalls placed on the branch, and a look-alike opcode with equal operands. Each case checks the ports at every cycle from reset until two cycles past the decision.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int INSTR_W = 32;
    localparam int ADDR_W  = 32;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;

    localparam logic [OPC_W-1:0]   OPC_BRANCH_EQ = 6'b000100;
    localparam logic [INSTR_W-1:0] NOP_WORD      = '0;
    localparam logic [ADDR_W-1:0]  WORD_BYTES    = ADDR_W'(4);

    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [ADDR_W-1:0]  pc4;
    } dec_entry_t;

    localparam dec_entry_t BUBBLE = '{instr: NOP_WORD, pc4: '0};

    function automatic logic is_branch_eq(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1 -: OPC_W] == OPC_BRANCH_EQ;
    endfunction

    function automatic logic [ADDR_W-1:0] branch_disp(input logic [INSTR_W-1:0] w);
        return {{(ADDR_W-IMM_W-2){w[IMM_W-1]}}, w[IMM_W-1:0], 2'b00};
    endfunction

endpackage

// File: rtl/brf_resolve.sv
module brf_resolve
    import brf_pkg::*;
(
    input  dec_entry_t         dec,
    input  logic [INSTR_W-1:0] opnd_a,
    input  logic [INSTR_W-1:0] opnd_b,
    input  logic               hold,
    output logic               redirect,
    output logic [ADDR_W-1:0]  dest
);
    logic br_kind;
    logic same;

    always_comb begin
        br_kind  = is_branch_eq(dec.instr);
        same     = (opnd_a == opnd_b);
        redirect = br_kind && same && !hold;
        dest     = dec.pc4 + branch_disp(dec.instr);
    end
endmodule

// File: rtl/brf_pc.sv
module brf_pc
    import brf_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] dest,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_next_seq
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        pc_next_seq = pc_q + WORD_BYTES;
        if (hold)          pc_d = pc_q;
        else if (redirect) pc_d = dest;
        else               pc_d = pc_next_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (!hold && !redirect) |=> pc_q == $past(pc_q) + WORD_BYTES);   // R2
    AST_PC_TARGET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> pc_q == $past(dest));                             // R5
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc_q));                                       // R8
endmodule

// File: rtl/brf_ifid.sv
module brf_ifid
    import brf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       squash,
    input  dec_entry_t fetched,
    output dec_entry_t dec
);
    dec_entry_t q;

    always_ff @(posedge clk) begin
        if (rst)         q <= BUBBLE;
        else if (hold)   q <= q;
        else if (squash) q <= BUBBLE;
        else             q <= fetched;
    end

    assign dec = q;

    AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (squash && !hold) |=> q.instr == NOP_WORD);                   // R6
    AST_DEC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!squash && !hold) |=> q == $past(fetched));                  // R3
    AST_DEC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));                                          // R8
endmodule

// File: rtl/brf_top.sv
module brf_top
    import brf_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        delay_mode,
    input  logic [31:0] imem_rdata,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    input  logic        stall,
    output logic [31:0] imem_addr,
    output logic [31:0] ifid_instr,
    output logic [31:0] ifid_pc4,
    output logic        br_taken
);
    logic              redirect;
    logic              squash;
    logic [ADDR_W-1:0] dest;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pc_seq;
    dec_entry_t        fetched;
    dec_entry_t        dec;

    brf_resolve u_resolve (
        .dec      (dec),
        .opnd_a   (rs_val),
        .opnd_b   (rt_val),
        .hold     (stall),
        .redirect (redirect),
        .dest     (dest)
    );

    brf_pc #(.RESET_PC(RESET_PC)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .hold        (stall),
        .redirect    (redirect),
        .dest        (dest),
        .pc          (pc),
        .pc_next_seq (pc_seq)
    );

    always_comb begin
        fetched.instr = imem_rdata;
        fetched.pc4   = pc_seq;
        squash        = redirect && !delay_mode;
    end

    brf_ifid u_ifid (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .squash  (squash),
        .fetched (fetched),
        .dec     (dec)
    );

    assign imem_addr  = pc;
    assign ifid_instr = dec.instr;
    assign ifid_pc4   = dec.pc4;
    assign br_taken   = redirect && !rst;

    AST_TAKEN_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (rs_val == rt_val) && !stall);                    // R4
    AST_DELAY_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (br_taken && delay_mode) |=> ifid_instr == $past(imem_rdata)); // R7
    AST_ONLY_BEQ_REDIRECTS: assert property (@(posedge clk) disable iff (rst)
        (ifid_instr[31:26] != OPC_BRANCH_EQ) |-> !br_taken);           // R9
endmodule

// File: tb/tb_brf_top.sv
module tb_brf_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        delay_mode = 1'b0;
    logic [31:0] imem_rdata;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        stall = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] ifid_instr;
    logic [31:0] ifid_pc4;
    logic        br_taken;

    logic [31:0] mem [64];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign imem_rdata = mem[imem_addr[7:2]];

    brf_top dut (
        .clk(clk), .rst(rst), .delay_mode(delay_mode), .imem_rdata(imem_rdata),
        .rs_val(rs_val), .rt_val(rt_val), .stall(stall), .imem_addr(imem_addr),
        .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4), .br_taken(br_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stall = 1'b0;
        rs_val = 32'h1;
        rt_val = 32'h2;
        step();
        step();
        chk("R1 pc", imem_addr, 32'h0);
        chk("R1 instr", ifid_instr, 32'h0);
        chk("R1 pc4", ifid_pc4, 32'h0);
        chk("R1 taken", {31'b0, br_taken}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic fill_plain();
        for (int i = 0; i < 64; i++) mem[i] = 32'h2400_0000 | 32'(i);
    endtask

    task automatic run_case(input bit mode, input int off, input bit eq,
                            input bit stl, input bit beq_op);
        logic [31:0] bw;
        int tgt;
        bit taken;
        string tag;
        fill_plain();
        bw = {beq_op ? 6'b000100 : 6'b000101, 5'd1, 5'd2, 16'(off)};
        mem[2] = bw;
        delay_mode = mode;
        do_reset();
        step();
        step();
        step();
        chk("R3 beq in decode", ifid_instr, bw);
        chk("R3 beq pc4", ifid_pc4, 32'd12);
        rs_val = 32'hA5A5_0000 | 32'(off & 16'hffff);
        rt_val = eq ? rs_val : rs_val ^ 32'h10;
        taken = eq && beq_op;
        tgt = 12 + off * 4;
        if (stl) begin
            stall = 1'b1;
            for (int k = 0; k < 2; k++) begin
                #1;
                chk("R8 taken low", {31'b0, br_taken}, 32'h0);
                step();
                chk("R8 pc held", imem_addr, 32'd12);
                chk("R8 instr held", ifid_instr, bw);
                chk("R8 pc4 held", ifid_pc4, 32'd12);
            end
            stall = 1'b0;
        end
        #1;
        tag = beq_op ? "R4 taken" : "R9 no redirect";
        chk(tag, {31'b0, br_taken}, {31'b0, taken});
        step();
        rs_val = 32'h1;
        rt_val = 32'h2;
        if (taken) begin
            chk("R5 target", imem_addr, 32'(tgt));
            if (mode) begin
                chk("R7 slot instr", ifid_instr, mem[3]);
                chk("R7 slot pc4", ifid_pc4, 32'd16);
            end else begin
                chk("R6 bubble instr", ifid_instr, 32'h0);
                chk("R6 bubble pc4", ifid_pc4, 32'h0);
                #1;
                chk("R6 bubble not taken", {31'b0, br_taken}, 32'h0);
            end
            step();
            chk("R5 fetch after target", imem_addr, 32'(tgt + 4));
            chk("R5 target instr", ifid_instr, mem[tgt/4]);
            chk("R5 target pc4", ifid_pc4, 32'(tgt + 4));
        end else begin
            tag = beq_op ? "R4 sequential pc" : "R9 sequential pc";
            chk(tag, imem_addr, 32'd16);
            chk("R4 next instr", ifid_instr, mem[3]);
            chk("R4 next pc4", ifid_pc4, 32'd16);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int offs [6] = '{-3, -1, 0, 1, 2, 5};
        fill_plain();
        do_reset();
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R2 sequential pc", imem_addr, 32'(4 * k));
            chk("R3 capture instr", ifid_instr, mem[k-1]);
            chk("R3 capture pc4", ifid_pc4, 32'(4 * k));
        end
        for (int m = 0; m < 2; m++)
            for (int o = 0; o < 6; o++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        run_case(m[0], offs[o], e[0], s[0], 1'b1);
        for (int m = 0; m < 2; m++)
            run_case(m[0], 4, 1'b1, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule